// File: doc/BRIEF.md
# Paper Tape Loader Word Decoder

This block sits behind a paper tape reader and turns its stream of 8-bit characters into memory writes. Every 12-bit word is carried as two characters that each contribute six payload bits: the upper half arrives first and the lower half second. A marker bit in the first character of a pair tells whether the word is a load address or a data word. Characters with the most significant bit set are discarded without affecting anything. An example is the rubout value used to erase punching mistakes.

An address word is held as the current load address. A data word is written to the held address through a one-cycle write strobe. After that write the held address returns to zero, because the tape format puts a fresh address in front of every data word. A status output shows whether the most recent complete word was an address. The block never stalls the character source: its ready output is always high.

Top module: `tape_rim_decoder`

## Requirements
- R1: A word is formed from two accepted characters: the low 6 bits of the first give word bits 11..6, and the low 6 bits of the second give word bits 5..0.
- R2: A pair whose first character has bit 6 set (octal 0100) is an address, and a pair whose first character has bit 6 clear is data. `last_was_addr` goes high the cycle after an address pair completes and low the cycle after a data pair completes.
- R3: A character with bit 7 set (for example octal 0377) is dropped. It does not advance the pairing, causes no write and leaves `last_was_addr` unchanged.
- R4: When the second character of a data pair is accepted in cycle N, `wr_en` is high for exactly cycle N+1. In that cycle `wr_addr` carries the held address and `wr_data` carries the data word.
- R5: After a data write the held address is zero, so a data pair that is not preceded by a new address pair is written to address 0000.
- R6: Bit 6 of the second character of a pair has no effect on the word or on its address/data classification.
- R7: `char_ready` is high at all times once reset is released.
- R8: While reset is active and after it is released, `wr_en` and `last_was_addr` are low, the held address is zero, and the next accepted character is treated as the first of a pair, even if reset came in the middle of a pair.
- R9: The character sequence 0112, 0034, 0377, 0055, 0033 (octal) writes 5533 to address 1234.
- R10: Cycles in which `char_valid` is low do not change the pairing and cause no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| char_valid | input | 1 | Tape character present on `char_data` this cycle |
| char_data | input | 8 | Tape character |
| char_ready | output | 1 | Always high: the block accepts every character |
| wr_en | output | 1 | One-cycle memory write strobe |
| wr_addr | output | 12 | Write address |
| wr_data | output | 12 | Write data |
| last_was_addr | output | 1 | High when the most recent complete word was an address |

## Verification
The bench places rubouts and other high-bit characters between the two halves of a pair. A design that counted them would split words across the wrong characters and write garbage. It sends data pairs with no address in front, where a design that kept or incremented the held address would write to a nonzero location instead of 0000. It sets bit 6 on second characters, which a careless classifier would turn into address updates. It also resets in the middle of a pair, where stale pairing state would swap a word's halves. Back-to-back and gapped characters check the strobe timing: a design that writes a cycle early or late, or holds the strobe for two cycles, misses the expected sample.

// File: rtl/tape_rim_pkg.sv
package tape_rim_pkg;

  // Default geometry of a tape character and of a loaded word
  parameter int unsigned DEF_CHAR_W = 8;
  parameter int unsigned DEF_SEG_W  = 6;

  // Which half of a word the next kept character supplies
  typedef enum logic {
    PH_HEAD = 1'b0,
    PH_TAIL = 1'b1
  } pair_phase_e;

endpackage

// File: rtl/tape_rst_sync.sv
module tape_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/tape_char_class.sv
module tape_char_class #(
  parameter int unsigned CHAR_W = tape_rim_pkg::DEF_CHAR_W,
  parameter int unsigned SEG_W  = tape_rim_pkg::DEF_SEG_W
) (
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_char,
  output logic              keep,
  output logic              marker,
  output logic [SEG_W-1:0]  payload
);

  localparam int unsigned DROP_BIT = CHAR_W - 1;
  localparam int unsigned MARK_BIT = SEG_W;

  // The drop bit must sit above the marker bit
  generate
    if (DROP_BIT <= MARK_BIT) begin : g_bad_geometry
      initial $error("tape_char_class: CHAR_W must exceed SEG_W + 1");
    end
  endgenerate

  always_comb begin
    keep    = in_valid && !in_char[DROP_BIT];
    marker  = in_char[MARK_BIT];
    payload = in_char[SEG_W-1:0];
  end

endmodule

// File: rtl/tape_pair_join.sv
module tape_pair_join #(
  parameter int unsigned SEG_W = tape_rim_pkg::DEF_SEG_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 keep,
  input  logic                 marker,
  input  logic [SEG_W-1:0]     payload,
  output logic                 word_stb,
  output logic                 word_is_addr,
  output logic [2*SEG_W-1:0]   word
);

  import tape_rim_pkg::*;

  pair_phase_e      phase_q, phase_d;
  logic [SEG_W-1:0] hi_q, hi_d;
  logic             mark_q, mark_d;
  logic             head_en;

  // Next-state logic
  always_comb begin
    phase_d      = phase_q;
    hi_d         = hi_q;
    mark_d       = mark_q;
    head_en      = 1'b0;
    word_stb     = 1'b0;
    word_is_addr = mark_q;
    word         = {hi_q, payload};
    if (keep) begin
      if (phase_q == PH_HEAD) begin
        head_en = 1'b1;
        hi_d    = payload;
        mark_d  = marker;
        phase_d = PH_TAIL;
      end else begin
        word_stb = 1'b1;
        phase_d  = PH_HEAD;
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HEAD;
    end else if (keep) begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      mark_q <= 1'b0;
    end else if (head_en) begin
      hi_q   <= hi_d;
      mark_q <= mark_d;
    end
  end

endmodule

// File: rtl/tape_load_unit.sv
module tape_load_unit #(
  parameter int unsigned WORD_W = 2 * tape_rim_pkg::DEF_SEG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_stb,
  input  logic              word_is_addr,
  input  logic [WORD_W-1:0] word,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              last_was_addr
);

  logic [WORD_W-1:0] addr_q, addr_d;
  logic              flag_q, flag_d;
  logic              wen_q, wen_d;
  logic [WORD_W-1:0] waddr_q, waddr_d;
  logic [WORD_W-1:0] wdata_q, wdata_d;
  logic              data_en;

  // Next-state logic
  always_comb begin
    addr_d  = addr_q;
    flag_d  = flag_q;
    wen_d   = 1'b0;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    data_en = 1'b0;
    if (word_stb) begin
      if (word_is_addr) begin
        addr_d = word;
        flag_d = 1'b1;
      end else begin
        data_en = 1'b1;
        wen_d   = 1'b1;
        waddr_d = addr_q;
        wdata_d = word;
        addr_d  = '0;
        flag_d  = 1'b0;
      end
    end
  end

  // Held address and status, enabled per completed word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      flag_q <= 1'b0;
    end else if (word_stb) begin
      addr_q <= addr_d;
      flag_q <= flag_d;
    end
  end

  // Strobe register, free running so the pulse ends by itself
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q <= 1'b0;
    end else begin
      wen_q <= wen_d;
    end
  end

  // Write payload, enabled only on data words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= '0;
      wdata_q <= '0;
    end else if (data_en) begin
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
    end
  end

  assign wr_en         = wen_q;
  assign wr_addr       = waddr_q;
  assign wr_data       = wdata_q;
  assign last_was_addr = flag_q;

endmodule

// File: rtl/tape_rim_decoder.sv
module tape_rim_decoder #(
  parameter int unsigned CHAR_W = tape_rim_pkg::DEF_CHAR_W,
  parameter int unsigned SEG_W  = tape_rim_pkg::DEF_SEG_W,
  parameter int unsigned WORD_W = 2 * SEG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_valid,
  input  logic [CHAR_W-1:0] char_data,
  output logic              char_ready,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              last_was_addr
);

  logic              rst_sync_n;
  logic              keep;
  logic              marker;
  logic [SEG_W-1:0]  payload;
  logic              word_stb;
  logic              word_is_addr;
  logic [WORD_W-1:0] word;

  tape_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tape_char_class #(.CHAR_W(CHAR_W), .SEG_W(SEG_W)) u_class (
    .in_valid (char_valid),
    .in_char  (char_data),
    .keep     (keep),
    .marker   (marker),
    .payload  (payload)
  );

  tape_pair_join #(.SEG_W(SEG_W)) u_join (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .keep         (keep),
    .marker       (marker),
    .payload      (payload),
    .word_stb     (word_stb),
    .word_is_addr (word_is_addr),
    .word         (word)
  );

  tape_load_unit #(.WORD_W(WORD_W)) u_load (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .word_stb      (word_stb),
    .word_is_addr  (word_is_addr),
    .word          (word),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .last_was_addr (last_was_addr)
  );

  // No backpressure toward the reader
  assign char_ready = 1'b1;

endmodule

// File: rtl/tape_rim_checker.sv
module tape_rim_checker #(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned WORD_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              char_valid,
  input logic [CHAR_W-1:0] char_data,
  input logic              wr_en,
  input logic              last_was_addr
);

  p_drop_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && char_data[CHAR_W-1]) |=> !wr_en);

  p_drop_keeps_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && char_data[CHAR_W-1]) |=> $stable(last_was_addr));

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  p_write_clears_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !last_was_addr);

  p_idle_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !char_valid |=> !wr_en);

endmodule

bind tape_rim_decoder tape_rim_checker #(.CHAR_W(CHAR_W), .WORD_W(WORD_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .char_valid    (char_valid),
  .char_data     (char_data),
  .wr_en         (wr_en),
  .last_was_addr (last_was_addr)
);

// File: tb/tape_rim_decoder_tb.sv
`timescale 1ns/1ps
module tape_rim_decoder_tb;

  logic        clk;
  logic        rst_n;
  logic        char_valid;
  logic [7:0]  char_data;
  logic        char_ready;
  logic        wr_en;
  logic [11:0] wr_addr;
  logic [11:0] wr_data;
  logic        last_was_addr;

  int n_chk;
  int n_bad;

  // Reference model state
  bit          m_tail;
  logic [5:0]  m_hi;
  bit          m_mark;
  logic [11:0] m_addr;
  bit          m_flag;

  tape_rim_decoder u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .char_valid    (char_valid),
    .char_data     (char_data),
    .char_ready    (char_ready),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .last_was_addr (last_was_addr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input logic [11:0] act, input logic [11:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%o exp=%o", tag, act, exp);
    end
  endtask

  function automatic void model_reset();
    m_tail = 1'b0;
    m_hi   = '0;
    m_mark = 1'b0;
    m_addr = '0;
    m_flag = 1'b0;
  endfunction

  // Entered and left at a falling edge
  task automatic send_char(input logic [7:0] c, input int gap, input string req);
    bit          exp_wr;
    logic [11:0] ea;
    logic [11:0] ed;
    exp_wr = 1'b0;
    ea = '0;
    ed = '0;
    char_valid = 1'b1;
    char_data  = c;
    @(negedge clk);
    char_valid = 1'b0;
    if (!c[7]) begin
      if (!m_tail) begin
        m_hi   = c[5:0];
        m_mark = c[6];
        m_tail = 1'b1;
      end else begin
        m_tail = 1'b0;
        if (m_mark) begin
          m_addr = {m_hi, c[5:0]};
          m_flag = 1'b1;
        end else begin
          exp_wr = 1'b1;
          ea     = m_addr;
          ed     = {m_hi, c[5:0]};
          m_addr = '0;
          m_flag = 1'b0;
        end
      end
    end
    chk({11'b0, wr_en}, {11'b0, exp_wr}, {req, " R4 wr_en"});
    if (exp_wr) begin
      chk(wr_addr, ea, {req, " R4 wr_addr"});
      chk(wr_data, ed, {req, " R1 wr_data"});
    end
    chk({11'b0, last_was_addr}, {11'b0, m_flag}, {req, " R2 last_was_addr"});
    chk({11'b0, char_ready}, 12'd1, {req, " R7 char_ready"});
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      chk({11'b0, wr_en}, 12'd0, {req, " R10 idle wr_en"});
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    char_valid = 1'b0;
    char_data  = '0;
    repeat (3) @(negedge clk);
    chk({11'b0, wr_en}, 12'd0, "R8 wr_en in reset");
    chk({11'b0, last_was_addr}, 12'd0, "R8 flag in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({11'b0, wr_en}, 12'd0, "R8 wr_en after reset");
    chk({11'b0, char_ready}, 12'd1, "R7 ready after reset");
    model_reset();
  endtask

  function automatic logic [7:0] rand_char();
    int unsigned r;
    r = $urandom % 16;
    if (r == 0)      return 8'o377;
    else if (r == 1) return 8'h80 | 8'($urandom % 128);
    else             return 8'($urandom % 128);
  endfunction

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h0000_5eed));
    n_chk = 0;
    n_bad = 0;
    model_reset();
    @(negedge clk);
    do_reset();

    // R9: the worked example with a rubout between the pairs
    send_char(8'o112, 0, "R9");
    send_char(8'o034, 0, "R9");
    send_char(8'o377, 0, "R9 R3");
    send_char(8'o055, 0, "R9");
    send_char(8'o033, 1, "R9");

    // R5: data with no new address goes to 0000
    send_char(8'o012, 2, "R5");
    send_char(8'o047, 1, "R5");

    // R3: high-bit characters inside a pair do not advance it
    send_char(8'o141, 0, "R3");
    send_char(8'o377, 0, "R3");
    send_char(8'o200, 1, "R3");
    send_char(8'o305, 0, "R3");
    send_char(8'o022, 0, "R3");
    send_char(8'o077, 0, "R3");
    send_char(8'o377, 0, "R3");
    send_char(8'o001, 2, "R3");

    // R6: marker bit on the second character is ignored
    send_char(8'o055, 0, "R6");
    send_char(8'o133, 1, "R6");
    send_char(8'o177, 0, "R6");
    send_char(8'o177, 0, "R6");
    send_char(8'o000, 0, "R6");
    send_char(8'o100, 0, "R6");

    // R8: reset in the middle of a pair
    send_char(8'o112, 0, "R8");
    do_reset();
    send_char(8'o055, 0, "R8");
    send_char(8'o033, 1, "R8");

    // Random stream, R1 R2 R3 R4 R10
    for (int k = 0; k < 400; k++) begin
      send_char(rand_char(), int'($urandom % 3), "RND");
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule